// File: doc/BRIEF.md
# Key-Protected Reset Mode Entry Controller

This block sits on a simple 32-bit register bus and lets software ask for a chip-level reset. Software picks the kind of reset in a configuration register, arms a pending change in an update register, and then commits it with a two-word unlock sequence on a key register. Only a correctly ordered key pair written while a change is armed produces a reset request. Stray writes, a wrong key, or a key pair with nothing armed have no effect on the outputs.

On a commit the block raises one of two request lines for exactly one clock: a destructive request or a functional request. The destructive request wins when both are selected. The armed bit then clears itself, and a status bit records which kind of reset was last taken. A standby selection bit is stored and can be read back, but it requests nothing.

Top module: `mode_entry_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After it, every register reads zero, both request outputs are low and `bus_rdata` is zero.
- R2: The configuration register at offset 0x4 stores bit 0 (destructive select), bit 1 (functional select) and bit 15 (standby select). These bits read back as written and all other bits read zero. The standby bit never raises a request.
- R3: The update register at offset 0x8 stores bit 0 (armed), which can be read back. The status register at offset 0xC shows the last-taken reset in bit 0.
- R4: Reads of the key register at offset 0x0 return zero. Writes to any other offset, including unaligned ones, change nothing, and reads of those offsets return zero. A read returns data in the cycle after the address is presented.
- R5: When bits 15:0 of a key-register write equal 0x5AF0, and the very next bus write is a key-register write whose bits 15:0 equal 0xA50F, the sequence commits while the update bit is set. Bits 31:16 of a key write are ignored. The request output is high during the second cycle after the edge that takes the inverted key, and for that one cycle only.
- R6: On a commit, config bit 0 raises `dest_rst_req`. If bit 0 is clear and bit 1 is set, `func_rst_req` is raised instead. The two outputs are never high together.
- R7: The sequence does not commit if the inverted key arrives without a directly preceding direct key, if any other bus write comes between the two keys, or if a key write carries any other value. A repeated direct key restarts the sequence.
- R8: A key pair that arrives while the update bit is clear raises no request and leaves the status register unchanged.
- R9: A commit clears the update bit. It sets status bit 0 to 1 for a destructive reset and to 0 for a functional reset. A commit with neither bit selected raises nothing and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| dest_rst_req | output | 1 | One-cycle destructive reset request |
| func_rst_req | output | 1 | One-cycle functional reset request |

## Verification
Several properties are checked on every cycle: the request outputs are exclusive and last one cycle, a commit is only possible after a direct key has been taken and while the update bit is set, and the update bit has cleared by the time a request is visible. The choice of reset type for each configuration, the stored status value, the ignoring of bad sequences and stray offsets, and the read latency can only be shown by the bench. It sweeps every configuration combination with and without an armed update, and plays a set of broken and valid key orders.

// File: rtl/mec_pkg.sv
package mec_pkg;
  localparam logic [15:0] KEY_DIRECT = 16'h5AF0;
  localparam logic [15:0] KEY_INVERT = 16'hA50F;

  localparam int OFS_KEY  = 'h0;
  localparam int OFS_CFG  = 'h4;
  localparam int OFS_UPD  = 'h8;
  localparam int OFS_STAT = 'hC;

  localparam int CFG_DEST_BIT = 0;
  localparam int CFG_FUNC_BIT = 1;
  localparam int CFG_STBY_BIT = 15;

  typedef enum logic {SEQ_IDLE, SEQ_HALF} seq_e;

  typedef struct packed {
    logic stby;
    logic func;
    logic dest;
  } cfg_t;
endpackage

// File: rtl/mec_key_seq.sv
module mec_key_seq
  import mec_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_any,
  input  logic             wr_key,
  input  logic [KEY_W-1:0] key,
  output logic             unlock_o
);
  seq_e state_q;
  logic unlock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= 1'b0;
      if (wr_any) begin
        if (wr_key && key == KEY_W'(KEY_DIRECT)) begin
          state_q <= SEQ_HALF;
        end else if (wr_key && key == KEY_W'(KEY_INVERT) && state_q == SEQ_HALF) begin
          state_q  <= SEQ_IDLE;
          unlock_q <= 1'b1;
        end else begin
          state_q <= SEQ_IDLE;
        end
      end
    end
  end

  assign unlock_o = unlock_q;

  // R7: an unlock is only seen after the sequencer held a direct key
  a_r7_unlock_after_half: assert property (@(posedge clk) disable iff (rst)
    unlock_q |-> $past(state_q == SEQ_HALF));
  // R5: the unlock strobe lasts a single cycle
  a_r5_unlock_single: assert property (@(posedge clk) disable iff (rst)
    unlock_q |=> !unlock_q);
endmodule

// File: rtl/mec_mode_regs.sv
module mec_mode_regs
  import mec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              wr_upd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlock_i,
  output cfg_t              cfg_o,
  output logic              upd_o,
  output logic              stat_o,
  output logic              dest_o,
  output logic              func_o
);
  cfg_t cfg_q;
  logic upd_q, stat_q, dest_q, func_q;
  logic commit;

  assign commit = unlock_i && upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      upd_q  <= 1'b0;
      stat_q <= 1'b0;
      dest_q <= 1'b0;
      func_q <= 1'b0;
    end else begin
      dest_q <= 1'b0;
      func_q <= 1'b0;
      if (wr_cfg) begin
        cfg_q.dest <= wdata[CFG_DEST_BIT];
        cfg_q.func <= wdata[CFG_FUNC_BIT];
        cfg_q.stby <= wdata[CFG_STBY_BIT];
      end
      if (commit) begin
        upd_q <= 1'b0;
        if (cfg_q.dest) begin
          dest_q <= 1'b1;
          stat_q <= 1'b1;
        end else if (cfg_q.func) begin
          func_q <= 1'b1;
          stat_q <= 1'b0;
        end
      end else if (wr_upd) begin
        upd_q <= wdata[0];
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign upd_o  = upd_q;
  assign stat_o = stat_q;
  assign dest_o = dest_q;
  assign func_o = func_q;

  // R6: requests are mutually exclusive
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dest_q, func_q}));
  // R5: each request lasts one cycle
  a_r5_dest_pulse: assert property (@(posedge clk) disable iff (rst)
    dest_q |=> !dest_q);
  a_r5_func_pulse: assert property (@(posedge clk) disable iff (rst)
    func_q |=> !func_q);
  // R8: a request needs an armed update on the previous cycle
  a_r8_needs_armed: assert property (@(posedge clk) disable iff (rst)
    (dest_q || func_q) |-> $past(upd_q));
  // R9: the update bit is clear when a request is visible
  a_r9_upd_cleared: assert property (@(posedge clk) disable iff (rst)
    (dest_q || func_q) |-> !upd_q);
  // R9: status agrees with the request taken
  a_r9_stat_tracks: assert property (@(posedge clk) disable iff (rst)
    (dest_q || func_q) |-> (stat_q == dest_q));
endmodule

// File: rtl/mec_rd_mux.sv
module mec_rd_mux
  import mec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  cfg_t              cfg,
  input  logic              upd,
  input  logic              stat,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(OFS_CFG)) begin
      rd_d[CFG_DEST_BIT] = cfg.dest;
      rd_d[CFG_FUNC_BIT] = cfg.func;
      rd_d[CFG_STBY_BIT] = cfg.stby;
    end else if (addr == ADDR_W'(OFS_UPD)) begin
      rd_d[0] = upd;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rd_d[0] = stat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mode_entry_ctrl.sv
module mode_entry_ctrl
  import mec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dest_rst_req,
  output logic              func_rst_req
);
  logic wr_key, wr_cfg, wr_upd, unlock;
  logic upd, stat;
  cfg_t cfg;

  assign wr_key = bus_we && (bus_addr == ADDR_W'(OFS_KEY));
  assign wr_cfg = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_upd = bus_we && (bus_addr == ADDR_W'(OFS_UPD));

  mec_key_seq #(.KEY_W(KEY_W)) u_seq (
    .clk(clk), .rst(rst), .wr_any(bus_we), .wr_key(wr_key),
    .key(bus_wdata[KEY_W-1:0]), .unlock_o(unlock)
  );

  mec_mode_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_upd(wr_upd),
    .wdata(bus_wdata), .unlock_i(unlock), .cfg_o(cfg), .upd_o(upd),
    .stat_o(stat), .dest_o(dest_rst_req), .func_o(func_rst_req)
  );

  mec_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .cfg(cfg), .upd(upd),
    .stat(stat), .rdata_o(bus_rdata)
  );

  // R5: a request follows an unlock by exactly one cycle
  a_r5_after_unlock: assert property (@(posedge clk) disable iff (rst)
    (dest_rst_req || func_rst_req) |-> $past(unlock));
endmodule

// File: tb/sim_mode_entry_ctrl.sv
module sim_mode_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dest_rst_req, func_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_stat = 1'b0;

  always #5 clk = ~clk;

  mode_entry_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dest_rst_req(dest_rst_req), .func_rst_req(func_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // after the inverted key write: expect request pattern over the next cycles
  task automatic watch(input string tag, input bit e_dest, input bit e_func);
    chk({tag, " idle before"}, {30'd0, dest_rst_req, func_rst_req}, 32'd0);
    @(negedge clk);
    chk({tag, " pulse"}, {30'd0, dest_rst_req, func_rst_req}, {30'd0, e_dest, e_func});
    @(negedge clk);
    chk({tag, " pulse ends"}, {30'd0, dest_rst_req, func_rst_req}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 outputs", {30'd0, dest_rst_req, func_rst_req}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(8'h4, r); chk("R1 cfg", r, 32'd0);
    rd(8'h8, r); chk("R1 upd", r, 32'd0);
    rd(8'hC, r); chk("R1 stat", r, 32'd0);

    // R2: config mask and readback
    wr(8'h4, 32'hFFFF_FFFF);
    rd(8'h4, r); chk("R2 cfg mask", r, 32'h0000_8003);
    // R4: key register reads zero, stray offsets ignored
    wr(8'h0, 32'h1234_5AF0);
    rd(8'h0, r); chk("R4 key reads zero", r, 32'd0);
    wr(8'h6, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'hFC, 32'h0);
    rd(8'h4, r); chk("R4 stray writes ignored", r, 32'h0000_8003);
    rd(8'h10, r); chk("R4 undefined read", r, 32'd0);
    // R3: update readback
    wr(8'h8, 32'h1);
    rd(8'h8, r); chk("R3 upd set", r, 32'd1);
    wr(8'h8, 32'h0);
    rd(8'h8, r); chk("R3 upd clear", r, 32'd0);

    // Sweep every config combination, armed or not (R2 R5 R6 R8 R9)
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 2; a++) begin
        logic [31:0] cw;
        bit ed, ef;
        cw = {16'd0, c[2], 13'd0, c[1], c[0]};
        ed = (a == 1) && c[0];
        ef = (a == 1) && !c[0] && c[1];
        wr(8'h4, cw);
        wr(8'h8, {31'd0, a[0]});
        wr(8'h0, {16'hBEEF, 16'h5AF0});
        wr(8'h0, {16'h7777, 16'hA50F});
        watch($sformatf("R5 R6 cfg=%0d armed=%0d", c, a), ed, ef);
        if (ed) exp_stat = 1'b1;
        else if (ef) exp_stat = 1'b0;
        rd(8'hC, r); chk($sformatf("R8 R9 stat cfg=%0d armed=%0d", c, a), r, {31'd0, exp_stat});
        rd(8'h8, r); chk($sformatf("R9 upd cleared cfg=%0d armed=%0d", c, a), r, 32'd0);
        rd(8'h4, r); chk($sformatf("R2 cfg readback %0d", c), r, cw);
      end
    end

    // R7: broken sequences, all armed with destructive selected
    wr(8'h4, 32'h1);
    wr(8'h8, 32'h1);
    wr(8'h0, 32'hA50F);
    watch("R7 inverted alone", 1'b0, 1'b0);
    wr(8'h0, 32'h5AF0);
    wr(8'h4, 32'h1);
    wr(8'h0, 32'hA50F);
    watch("R7 write between keys", 1'b0, 1'b0);
    wr(8'h0, 32'h5AF0);
    wr(8'h0, 32'h5AF1);
    wr(8'h0, 32'hA50F);
    watch("R7 bad key between", 1'b0, 1'b0);
    wr(8'h0, 32'hA50F);
    wr(8'h0, 32'h5AF0);
    watch("R7 reversed order", 1'b0, 1'b0);
    wr(8'h0, 32'h0);
    rd(8'h8, r); chk("R7 still armed", r, 32'd1);
    // R7: repeated direct key restarts, then commits; functional selected
    wr(8'h4, 32'h2);
    wr(8'h0, 32'h5AF0);
    wr(8'h0, 32'h5AF0);
    wr(8'h0, 32'hA50F);
    watch("R7 repeated direct", 1'b0, 1'b1);
    rd(8'hC, r); chk("R9 stat after func", r, 32'd0);
    // R8: pair while not armed after a commit
    wr(8'h4, 32'h1);
    wr(8'h0, 32'h5AF0);
    wr(8'h0, 32'hA50F);
    watch("R8 pair unarmed", 1'b0, 1'b0);
    rd(8'hC, r); chk("R8 stat unchanged", r, 32'd0);

    // R1: reset clears state again
    wr(8'h8, 32'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h4, r); chk("R1 cfg after reset", r, 32'd0);
    rd(8'h8, r); chk("R1 upd after reset", r, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule